// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers ten interrupt request lines, ranked from level 9 (most urgent) to level 0 (least urgent). For each cycle it picks the most urgent request that is both pending and enabled, and hands the instruction sequencer a service strobe together with the vector address of that level. The sequencer accepts with a handshake input. On acceptance the block clears the latched request. It also rewrites its enable mask: in flat mode the whole mask is cleared, and in nesting mode only the levels above the serviced one stay enabled.

The mask in force is always visible on an output so that the sequencer can stack it on acceptance. A return input reloads the mask from the value the sequencer pops. Software reaches four write-only registers: a control word, the enable mask, a force/clear word and a global enable. Every request pin is active-low and passes through a two-stage synchronizer. Some lines count a falling edge and remember it. Others are plain levels. Three lines can be switched between the two styles through the control word.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, svc_o is low, vec_o is 0x0000, mask_o is all zeros, the global enable is set and all lines use their default sensitivity (control word zero).
- R2: Among lines that are requesting and enabled (mask bit 1 = enabled), the highest level wins. vec_o = 4*(10-level), so level 9 gives 0x0004 and level 0 gives 0x0028. vec_o reads 0x0000 whenever svc_o is low.
- R3: A level request on a pin (irq_ni[k] low) appears on svc_o after the second rising edge that follows the pin change. A falling edge on an edge-sensitive line appears after the third.
- R4: On an edge-sensitive line, a high-to-low transition is latched even while the line is masked. The latch holds until the request is serviced or cleared. Line 4 is always edge-sensitive. Lines 1, 2 and 9 are edge-sensitive when control bit 0, 1 or 2 (respectively) is 1.
- R5: A level-sensitive request is not latched. Releasing the pin before service withdraws it.
- R6: With control bit 4 (nesting) at 0, acceptance clears every mask bit.
- R7: With control bit 4 at 1, acceptance clears the mask bits of the serviced level and of all lower levels, and keeps the higher bits.
- R8: A cycle with rti_i high loads the mask from rti_mask_i at the next edge. No acceptance takes place in that cycle.
- R9: A write to the mask register (address 1, data bits [9:0]) holds svc_o low in the write cycle and in the cycle after it.
- R10: The force/clear register (address 2) takes force bits in [9:0] and clear bits in [19:10]. They act on the pending latches one cycle after the write. A forced request is serviced once.
- R11: Lines 1, 2, 4, 7, 8 and 9 are external. An external line accepts a force only while it is edge-sensitive. Lines 0, 3, 5 and 6 are internal and can always be forced.
- R12: The global enable (address 3, data bit 0) being 0 keeps svc_o low whatever the mask holds. Writing 1 brings servicing back at once.
- R13: svc_o stays high until ack_i is seen with it. After acceptance the serviced request is cleared from the latch. The next cycle shows either no strobe or a strobe of strictly higher level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ni | input | 10 | Request pins, active low, bit k = level k |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 mask, 2 force/clear, 3 global enable |
| wr_data_i | input | 20 | Register write data |
| ack_i | input | 1 | Sequencer accepts the offered vector |
| rti_i | input | 1 | Return from interrupt: restore the mask |
| rti_mask_i | input | 10 | Mask value popped by the sequencer |
| svc_o | output | 1 | Service strobe |
| vec_o | output | 14 | Vector address of the selected level |
| mask_o | output | 10 | Mask in force; the value to stack on acceptance |

## Verification
Each result has a fixed latency:
- The strobe from a level pin is due after the second rising edge.
- The strobe from an edge is due after the third.
- Force, clear and re-enable after a mask write act after the second edge.
- Mask changes from acceptance or return, and changes of the global enable, show after the first edge.

Inputs change at falling edges, and every check samples at a falling edge placed exactly at these counts. Checks also land one edge early wherever the requirement says the strobe must still be absent. The priority table holds ack_i low, so each row observes the selection without disturbing the mask.

// File: rtl/irq_vec_pkg.sv
`timescale 1ns/1ps
package irq_vec_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_MASK = 2'd1,
    ADDR_FRC  = 2'd2,
    ADDR_GIE  = 2'd3
  } reg_addr_e;

  localparam int unsigned N_CFG    = 3;  // switchable-sensitivity lines
  localparam int unsigned NEST_BIT = 4;  // nesting enable in control word

endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int unsigned WIDTH   = 10,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{{WIDTH{RST_VAL}}}};
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/irq_latch.sv
`timescale 1ns/1ps
module irq_latch #(
  parameter int unsigned N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] act_i,     // synchronized request, active high
  input  logic [N-1:0] edge_i,    // 1 = edge-sensitive
  input  logic [N-1:0] frc_ok_i,  // force permitted
  input  logic [N-1:0] frc_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] srv_i,     // one-hot, serviced level
  output logic [N-1:0] req_o
);

  logic [N-1:0] pend_v;
  logic [N-1:0] clr_any;

  assign clr_any = clr_i | srv_i;

  for (genvar k = 0; k < N; k++) begin : g_line
    logic act_q, pend_q, set_ev;

    // new event wins over a clear in the same cycle
    assign set_ev = (edge_i[k] & act_i[k] & ~act_q) | (frc_i[k] & frc_ok_i[k]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        act_q  <= act_i[k];
        pend_q <= set_ev | (pend_q & ~clr_any[k]);
      end
    end

    assign pend_v[k] = pend_q;
    assign req_o[k]  = pend_q | (act_i[k] & ~edge_i[k]);
  end

  assert_pend_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pend_v) & ~$past(clr_any)) & ~pend_v) == '0));

endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int unsigned N      = 10,
  parameter int unsigned LVL_W  = $clog2(N),
  parameter int unsigned VEC_W  = 14,
  parameter int unsigned STRIDE = 4
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic [VEC_W-1:0] vec_o
);

  always_comb begin
    valid_o = |req_i;
    lvl_o   = '0;
    for (int k = 0; k < N; k++) begin
      if (req_i[k]) lvl_o = LVL_W'(k);
    end
    if (valid_o) begin
      assert_grant_top_R2: assert ((req_i >> lvl_o) == N'(1))
        else $error("grant is not the highest request");
    end
  end

  assign vec_o = valid_o ? VEC_W'(STRIDE * (N - 32'(lvl_o))) : '0;

endmodule

// File: rtl/irq_vec_ctrl.sv
`timescale 1ns/1ps
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned       N_SRC       = 10,
  parameter int unsigned       VEC_W       = 14,
  parameter int unsigned       VEC_STRIDE  = 4,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [N_SRC-1:0]  EDGE_LINES  = 10'b00_0001_0000,
  parameter logic [N_SRC-1:0]  EXT_LINES   = 10'b11_1001_0110,
  parameter int unsigned       CFG_LVL [N_CFG] = '{1, 2, 9}
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   irq_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [2*N_SRC-1:0] wr_data_i,
  input  logic               ack_i,
  input  logic               rti_i,
  input  logic [N_SRC-1:0]   rti_mask_i,
  output logic               svc_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [N_SRC-1:0]   mask_o
);

  localparam int unsigned LVL_W = $clog2(N_SRC);

  logic [N_CFG-1:0] cfg_q;
  logic             nest_q, gie_q, blk_q;
  logic [N_SRC-1:0] mask_q, frc_q, clr_q;
  logic [N_SRC-1:0] sync_n, act, edge_v, frc_ok, req, cand, srv;
  logic             any, accept, mask_wr;
  logic [LVL_W-1:0] lvl;
  logic [VEC_W-1:0] vec_raw;

  function automatic logic [N_SRC-1:0] keep_above(input logic [LVL_W-1:0] l);
    return {N_SRC{1'b1}} << (32'(l) + 1);
  endfunction

  irq_sync #(
    .WIDTH  (N_SRC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_ni),
    .q_o   (sync_n)
  );

  assign act = ~sync_n;

  always_comb begin
    edge_v = EDGE_LINES;
    for (int c = 0; c < N_CFG; c++) begin
      edge_v[LVL_W'(CFG_LVL[c])] = edge_v[LVL_W'(CFG_LVL[c])] | cfg_q[c];
    end
  end

  assign frc_ok = ~EXT_LINES | edge_v;

  irq_latch #(.N(N_SRC)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .act_i   (act),
    .edge_i  (edge_v),
    .frc_ok_i(frc_ok),
    .frc_i   (frc_q),
    .clr_i   (clr_q),
    .srv_i   (srv),
    .req_o   (req)
  );

  assign cand = req & mask_q;

  irq_arbiter #(
    .N     (N_SRC),
    .LVL_W (LVL_W),
    .VEC_W (VEC_W),
    .STRIDE(VEC_STRIDE)
  ) u_arb (
    .req_i  (cand),
    .valid_o(any),
    .lvl_o  (lvl),
    .vec_o  (vec_raw)
  );

  assign mask_wr = wr_en_i && (wr_addr_i == ADDR_MASK);
  assign svc_o   = any & gie_q & ~blk_q & ~rti_i & ~mask_wr;
  assign accept  = svc_o & ack_i;
  assign srv     = accept ? (N_SRC'(1) << lvl) : '0;
  assign vec_o   = svc_o ? vec_raw : '0;
  assign mask_o  = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      nest_q <= 1'b0;
      gie_q  <= 1'b1;
      blk_q  <= 1'b0;
      mask_q <= '0;
      frc_q  <= '0;
      clr_q  <= '0;
    end else begin
      blk_q <= mask_wr;
      frc_q <= '0;
      clr_q <= '0;
      if (wr_en_i) begin
        case (wr_addr_i)
          ADDR_CTRL: begin
            cfg_q  <= wr_data_i[N_CFG-1:0];
            nest_q <= wr_data_i[NEST_BIT];
          end
          ADDR_FRC: begin
            frc_q <= wr_data_i[N_SRC-1:0];
            clr_q <= wr_data_i[2*N_SRC-1:N_SRC];
          end
          ADDR_GIE: gie_q <= wr_data_i[0];
          default: ;
        endcase
      end
      // acceptance excludes rti and mask write in the same cycle
      if (accept)       mask_q <= nest_q ? (mask_q & keep_above(lvl)) : '0;
      else if (rti_i)   mask_q <= rti_mask_i;
      else if (mask_wr) mask_q <= wr_data_i[N_SRC-1:0];
    end
  end

  assert_entry_flat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !nest_q) |=> (mask_q == '0));

  assert_entry_nest_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && nest_q) |=> (mask_q == ($past(mask_q) & keep_above($past(lvl)))));

  assert_rti_restore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rti_i |=> (mask_q == $past(rti_mask_i)));

  assert_wr_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr |=> !svc_o);

  assert_one_shot_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (!svc_o || (vec_o < $past(vec_o))));

endmodule

// File: tb/test_irq_vec_ctrl.sv
`timescale 1ns/1ps
module test_irq_vec_ctrl;
  import irq_vec_pkg::*;

  localparam int unsigned N  = 10;
  localparam int unsigned VW = 14;

  // {mask[34:25], asserted lines[24:15], svc[14], vec[13:0]}; ack held low
  localparam logic [34:0] TBL [9] = '{
    {10'h3FF, 10'h001, 1'b1, 14'h0028},
    {10'h3FF, 10'h121, 1'b1, 14'h0008},
    {10'h2FF, 10'h121, 1'b1, 14'h0014},
    {10'h000, 10'h3EF, 1'b0, 14'h0000},
    {10'h008, 10'h0C8, 1'b1, 14'h001C},
    {10'h3FF, 10'h0C0, 1'b1, 14'h000C},
    {10'h3FF, 10'h000, 1'b0, 14'h0000},
    {10'h002, 10'h202, 1'b1, 14'h0024},
    {10'h3FF, 10'h202, 1'b1, 14'h0004}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   irq_n = '1;
  logic           wr_en = 1'b0;
  logic [1:0]     wr_addr = '0;
  logic [2*N-1:0] wr_data = '0;
  logic           ack = 1'b0;
  logic           rti = 1'b0;
  logic [N-1:0]   rti_mask = '0;
  logic           svc;
  logic [VW-1:0]  vec;
  logic [N-1:0]   mask;
  int             n_chk = 0;
  int             n_fail = 0;
  bit             done = 1'b0;

  always #2 clk = ~clk;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .irq_ni    (irq_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .ack_i     (ack),
    .rti_i     (rti),
    .rti_mask_i(rti_mask),
    .svc_o     (svc),
    .vec_o     (vec),
    .mask_o    (mask)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [2*N-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic take();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  task automatic ret(input logic [N-1:0] m);
    rti = 1'b1; rti_mask = m; tick(1); rti = 1'b0;
  endtask

  task automatic pulse(input int k);
    irq_n[k] = 1'b0; tick(1); irq_n[k] = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 svc", int'(svc), 0);
    chk("R1 vec", int'(vec), 0);
    chk("R1 mask", int'(mask), 0);

    // R2 priority table, level requests only
    for (int r = 0; r < 9; r++) begin
      irq_n = ~TBL[r][24:15];
      wr(ADDR_MASK, {10'b0, TBL[r][34:25]});
      tick(2);
      chk("R2 table svc", int'(svc), int'(TBL[r][14]));
      chk("R2 table vec", int'(vec), int'(TBL[r][13:0]));
    end
    irq_n = '1;
    wr(ADDR_MASK, '0);
    tick(3);

    // R4 edge latched while masked, R6 flat entry, R8 restore
    pulse(4);
    tick(3);
    chk("R4 masked edge no svc", int'(svc), 0);
    wr(ADDR_MASK, 20'h00010);
    tick(1);
    chk("R4 latched svc", int'(svc), 1);
    chk("R4 latched vec", int'(vec), 'h18);
    take();
    chk("R6 flat mask", int'(mask), 0);
    chk("R6 svc after entry", int'(svc), 0);
    ret(10'h010);
    chk("R8 mask restored", int'(mask), 'h010);
    chk("R13 latch cleared by service", int'(svc), 0);

    // R3 synchronizer latency on a level line
    wr(ADDR_MASK, 20'h00001);
    tick(1);
    irq_n[0] = 1'b0;
    tick(1);
    chk("R3 one edge early", int'(svc), 0);
    tick(1);
    chk("R3 due svc", int'(svc), 1);
    chk("R3 due vec", int'(vec), 'h28);

    // R9 mask write blocks one cycle
    wr(ADDR_MASK, 20'h00001);
    chk("R9 blocked", int'(svc), 0);
    tick(1);
    chk("R9 released", int'(svc), 1);

    // R12 global enable
    wr(ADDR_GIE, 20'h0);
    chk("R12 disabled", int'(svc), 0);
    tick(2);
    chk("R12 still disabled", int'(svc), 0);
    wr(ADDR_GIE, 20'h1);
    chk("R12 re-enabled", int'(svc), 1);

    // R13 strobe held without ack
    tick(3);
    chk("R13 held", int'(svc), 1);

    // R5 level withdrawn
    irq_n[0] = 1'b1;
    tick(2);
    chk("R5 withdrawn", int'(svc), 0);

    // R7 nesting
    wr(ADDR_CTRL, 20'h00010);
    wr(ADDR_MASK, 20'h003FF);
    tick(1);
    irq_n[5] = 1'b0;
    tick(2);
    chk("R7 level5 vec", int'(vec), 'h14);
    take();
    chk("R7 mask after level5", int'(mask), 'h3C0);
    chk("R7 lower masked", int'(svc), 0);
    irq_n[7] = 1'b0;
    tick(2);
    chk("R7 higher svc", int'(svc), 1);
    chk("R7 higher vec", int'(vec), 'h0C);
    take();
    chk("R7 mask after level7", int'(mask), 'h300);
    chk("R13 no strobe after entry", int'(svc), 0);
    irq_n = '1;
    tick(2);
    ret(10'h3C0);
    chk("R8 inner restore", int'(mask), 'h3C0);
    ret(10'h3FF);
    chk("R8 outer restore", int'(mask), 'h3FF);

    // R10 force an internal line, served once
    wr(ADDR_FRC, 20'h00040);
    chk("R10 force latency", int'(svc), 0);
    tick(1);
    chk("R10 forced svc", int'(svc), 1);
    chk("R10 forced vec", int'(vec), 'h10);
    take();
    ret(10'h3FF);
    chk("R10 served once", int'(svc), 0);

    // R11 force on external line only when edge-sensitive
    wr(ADDR_FRC, 20'h00004);
    tick(2);
    chk("R11 level line force ignored", int'(svc), 0);
    wr(ADDR_CTRL, 20'h00012);
    wr(ADDR_FRC, 20'h00004);
    tick(1);
    chk("R11 edge line forced svc", int'(svc), 1);
    chk("R11 edge line forced vec", int'(vec), 'h20);
    take();
    ret(10'h3FF);
    chk("R11 served", int'(svc), 0);

    // R10 clear a latched edge
    wr(ADDR_MASK, 20'h0);
    tick(1);
    pulse(4);
    tick(3);
    wr(ADDR_FRC, 20'h04000);
    tick(1);
    wr(ADDR_MASK, 20'h003FF);
    tick(1);
    chk("R10 cleared latch", int'(svc), 0);

    // R4 switchable line 9 as edge, R7 top level entry
    wr(ADDR_CTRL, 20'h00014);
    pulse(9);
    tick(3);
    chk("R4 line9 edge vec", int'(vec), 'h04);
    take();
    chk("R7 top entry mask", int'(mask), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule